// File: doc/BRIEF.md
# Configuration lock key sequencer

This block guards the pin configuration of a port. Software arms a freeze by writing the lock register three times in a row: the key bit (bit 16) goes 1, then 0, then 1, while bits 15:0 carry the same pin mask in every write. When that pattern completes, the key bit reads 1 and the mask is presented to the register file as a frozen-pin mask. The register file then refuses changes to the mode, output type, speed, pull and alternate-function fields of every pin whose mask bit is set. The freeze cannot be undone until reset.

The block sees only accesses aimed at the lock register: a write strobe, the write data and a flag that says whether the access is a full 32-bit word. Reads need no strobe. They do not disturb the sequence, and the read data is always available on its own port. A write that does not fit the expected step restarts detection. If that write could itself be a first step, it is taken as one; otherwise the sequencer drops back to idle. A byte or halfword write cancels an attempt in progress.

Top module: `cfg_lock_keyseq`

## Requirements
- R1: After reset, every bit of the read data is 0 and the frozen-pin mask is 0.
- R2: While the key is not active, a word write stores write data bits 15:0 as the mask; the value reads back on read data bits 15:0 in the next cycle.
- R3: Three word writes with key bit 16 equal to 1, then 0, then 1, all carrying the same bits 15:0, activate the key. From the next cycle on, read data bit 16 is 1 and the frozen-pin mask equals the stored mask.
- R4: If the second or third write of the sequence carries a mask that differs from the first, the sequence is aborted and the key stays inactive.
- R5: A byte or halfword write (word flag 0) leaves the stored mask unchanged and cancels any sequence in progress.
- R6: A write that is wrong for the current step restarts detection. If it has key bit 1, it counts as a new first step, so key patterns 1,1,0,1 and 1,0,0,1,0,1 with a constant mask both activate the key on their last write.
- R7: Once the key is active, no write of any kind changes read data bits 16:0 or the frozen-pin mask until reset.
- R8: Read data bits 31:17 always read 0.
- R9: While the key is inactive, the frozen-pin mask is 0, whatever value the stored mask holds.
- R10: Cycles with no write between the key writes do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the lock register |
| wr_word | input | 1 | 1 when the write is a full 32-bit word access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Lock register read data: mask in 15:0, key-active in 16 |
| frozen_mask | output | 16 | Per-pin freeze mask for the register file |

## Verification
The third key write does two things in one cycle: it stores the mask and it engages the freeze. That same write, if its mask or key bit is wrong, instead aborts the old attempt and possibly starts a new one. The bench provokes both cases with streams of word writes drawn from only two mask values and a random key bit, so that completions, aborts and restarts fall close together. Sub-word writes are mixed in among them. The cycle after each write, a reference model of the step rules gives the expected read data and frozen mask, and the bench compares the design's outputs against it.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
    // Progress through the key pattern
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ONE  = 2'd1,
        KS_ZERO = 2'd2
    } key_step_t;
endpackage

// File: rtl/cfg_lock_fsm.sv
// Key pattern detector. Tracks the 1,0,1 key bit pattern across word writes
// and raises a sticky lock flag when the pattern completes with an unchanged
// mask. Assumes mask_same compares the incoming mask with the stored one.
module cfg_lock_fsm
    import cfg_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_word,
    input  logic key_bit,
    input  logic mask_same,
    output logic locked
);
    key_step_t step_q, step_d;
    logic      lock_d;

    // Next step and lock decision for the current write
    always_comb begin
        step_d = step_q;
        lock_d = locked;
        if (wr_en && !locked) begin
            if (!wr_word) begin
                step_d = KS_IDLE;
            end else begin
                unique case (step_q)
                    KS_IDLE: step_d = key_bit ? KS_ONE : KS_IDLE;
                    KS_ONE: begin
                        if (!key_bit && mask_same) step_d = KS_ZERO;
                        else                       step_d = key_bit ? KS_ONE : KS_IDLE;
                    end
                    KS_ZERO: begin
                        if (key_bit && mask_same) begin
                            lock_d = 1'b1;
                            step_d = KS_IDLE;
                        end else begin
                            step_d = key_bit ? KS_ONE : KS_IDLE;
                        end
                    end
                    default: step_d = KS_IDLE;
                endcase
            end
        end
    end

    // Step and lock registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= KS_IDLE;
            locked <= 1'b0;
        end else begin
            step_q <= step_d;
            locked <= lock_d;
        end
    end
endmodule

// File: rtl/cfg_lock_mask.sv
// Stored pin mask. Loads on word writes while unlocked and reports whether
// the incoming mask equals the stored one. Assumes locked comes from the FSM.
module cfg_lock_mask #(
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic              locked,
    input  logic [MASK_W-1:0] wr_mask,
    output logic [MASK_W-1:0] mask_q,
    output logic              mask_same
);
    // Compare incoming mask with stored value
    always_comb mask_same = (wr_mask == mask_q);

    // Mask register, writable only before the key engages
    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '0;
        else if (wr_en && wr_word && !locked)     mask_q <= wr_mask;
    end
endmodule

// File: rtl/cfg_lock_keyseq.sv
// Top of the lock key sequencer. Joins the mask register and the key
// pattern detector and forms the read data and frozen-pin mask.
// Assumes the bus strobes wr_en only for writes aimed at the lock register.
module cfg_lock_keyseq #(
    parameter int DATA_W = 32,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [MASK_W-1:0] frozen_mask
);
    localparam int KEY_POS = MASK_W;
    localparam int PAD_W   = DATA_W - MASK_W - 1;

    logic [MASK_W-1:0] mask_q;
    logic              mask_same;
    logic              locked;

    cfg_lock_mask #(.MASK_W(MASK_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .locked    (locked),
        .wr_mask   (wr_data[MASK_W-1:0]),
        .mask_q    (mask_q),
        .mask_same (mask_same)
    );

    cfg_lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .key_bit   (wr_data[KEY_POS]),
        .mask_same (mask_same),
        .locked    (locked)
    );

    // Read data layout and freeze output
    always_comb begin
        rd_data     = {{PAD_W{1'b0}}, locked, mask_q};
        frozen_mask = locked ? mask_q : '0;
    end
endmodule

// File: rtl/cfg_lock_keyseq_chk.sv
// Property checker for the lock key sequencer, attached by bind.
module cfg_lock_keyseq_chk #(
    parameter int DATA_W = 32,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_word,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [MASK_W-1:0] frozen_mask
);
    a_r7_key_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MASK_W] |=> rd_data[MASK_W]);
    a_r7_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MASK_W] |=> $stable(rd_data[MASK_W-1:0]));
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:MASK_W+1] == '0);
    a_r9_no_freeze_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[MASK_W] |-> frozen_mask == '0);
    a_r3_freeze_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MASK_W] |-> frozen_mask == rd_data[MASK_W-1:0]);
    a_r3_lock_on_key_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_word && wr_data[MASK_W])) |=> !$rose(rd_data[MASK_W]));
    a_r2_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word && !rd_data[MASK_W]) |=> rd_data[MASK_W-1:0] == $past(wr_data[MASK_W-1:0]));
    a_r5_subword_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_word) |=> $stable(rd_data[MASK_W-1:0]));
endmodule

bind cfg_lock_keyseq cfg_lock_keyseq_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .rd_data(rd_data), .frozen_mask(frozen_mask)
);

// File: tb/cfg_lock_keyseq_test.sv
`timescale 1ns/1ps
module cfg_lock_keyseq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [15:0] frozen_mask;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    int        m_step;
    logic [15:0] m_mask;
    bit        m_lock;

    always #2 clk = ~clk;

    cfg_lock_keyseq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_data(wr_data), .rd_data(rd_data), .frozen_mask(frozen_mask)
    );

    function automatic logic [31:0] exp_rd();
        return {15'd0, m_lock, m_mask};
    endfunction

    function automatic logic [15:0] exp_frz();
        return m_lock ? m_mask : 16'd0;
    endfunction

    task automatic model_write(input logic [31:0] d, input bit word);
        bit same;
        bit key;
        if (m_lock) return;
        if (!word) begin m_step = 0; return; end
        same = (d[15:0] == m_mask);
        key  = d[16];
        case (m_step)
            0: m_step = key ? 1 : 0;
            1: m_step = (!key && same) ? 2 : (key ? 1 : 0);
            default: begin
                if (key && same) begin m_lock = 1; m_step = 0; end
                else m_step = key ? 1 : 0;
            end
        endcase
        m_mask = d[15:0];
    endtask

    task automatic check(input string tag);
        total++;
        if (rd_data !== exp_rd() || frozen_mask !== exp_frz()) begin
            bad++;
            $display("FAIL %s rd=%h frz=%h expected rd=%h frz=%h",
                     tag, rd_data, frozen_mask, exp_rd(), exp_frz());
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_step = 0; m_mask = '0; m_lock = 0;
    endtask

    task automatic wr(input logic [31:0] d, input bit word, input string tag);
        wr_en = 1'b1; wr_word = word; wr_data = d;
        @(posedge clk);
        model_write(d, word);
        @(negedge clk);
        wr_en = 1'b0;
        check(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        check("R1 reset state");

        // R2 / R9 plain mask write while unlocked
        wr(32'h0000_a5c3, 1, "R2 R9 mask store");
        // R3 basic sequence; R10 idle gaps between writes
        wr(32'h0001_00f0, 1, "R3 step1");
        idle(3);
        wr(32'h0000_00f0, 1, "R10 step2 after gap");
        idle(2);
        wr(32'h0001_00f0, 1, "R3 lock engaged");
        // R7 writes after lock ignored
        wr(32'h0000_ffff, 1, "R7 word write ignored");
        wr(32'h0001_1234, 0, "R7 subword ignored");
        // R8 reserved bits with all-ones data
        wr(32'hffff_ffff, 1, "R8 reserved zero");

        // R4 mask change on step 2 and step 3
        do_reset();
        wr(32'h0001_0011, 1, "R4 s1");
        wr(32'h0000_0012, 1, "R4 step2 mask differs");
        wr(32'h0001_0012, 1, "R4 no lock");
        do_reset();
        wr(32'h0001_0011, 1, "R4 s1b");
        wr(32'h0000_0011, 1, "R4 s2b");
        wr(32'h0001_0013, 1, "R4 step3 mask differs");

        // R5 subword aborts and keeps mask
        do_reset();
        wr(32'h0001_0077, 1, "R5 s1");
        wr(32'h0000_0077, 1, "R5 s2");
        wr(32'h0001_0099, 0, "R5 subword keeps mask");
        wr(32'h0001_0077, 1, "R5 sequence aborted");

        // R6 restart patterns
        do_reset();
        wr(32'h0001_0300, 1, "R6 a1");
        wr(32'h0001_0300, 1, "R6 a2");
        wr(32'h0000_0300, 1, "R6 a3");
        wr(32'h0001_0300, 1, "R6 pattern 1101 locks");
        do_reset();
        wr(32'h0001_0440, 1, "R6 b1");
        wr(32'h0000_0440, 1, "R6 b2");
        wr(32'h0000_0440, 1, "R6 b3");
        wr(32'h0001_0440, 1, "R6 b4");
        wr(32'h0000_0440, 1, "R6 b5");
        wr(32'h0001_0440, 1, "R6 pattern 100101 locks");

        // random mix
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            bit word;
            if ((i % 37) == 36) do_reset();
            d = $urandom();
            d[15:0] = ($urandom_range(0, 3) == 0) ? 16'h5a5a : 16'h0c30;
            word = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 4) == 0) idle(1);
            wr(d, word, "R3 R4 R5 R6 R7 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule